// File: doc/BRIEF.md
# Reduced Five-State Mealy Sequence Machine

This block is a synchronous Mealy state machine with one input bit and one output bit. Its behaviour comes from a fixed eight-state transition and output table. Equivalent states in that table are merged before the machine is built, so the hardware holds only five states in a 3-bit binary code. At each rising clock edge the machine reads `x_in` and moves to its next state. The output `z_out` is a combinational function of the present state and the present `x_in`.

The five states are named after the table rows they stand for. `S_AC` covers rows A and C. `S_BE` covers rows B and E. `S_DH` covers rows D and H. `S_F` and `S_G` each stand alone. The reset pin is active low. Asserting it clears the machine at once, without a clock edge. Releasing it takes effect through a two-flop synchroniser, so the internal reset drops after two rising edges.

Top module: `mealy_reduced_fsm`

## Requirements
- R1: While `rst_n` is low, the machine is in `S_AC` (code 0) and `z_out` is 0 for either value of `x_in`. This takes effect without waiting for a clock edge.
- R2: In `S_AC`, `x_in`=0 moves to `S_F` and `x_in`=1 moves to `S_BE`. Both give `z_out`=0.
- R3: In `S_BE`, `x_in`=0 moves to `S_DH` and `x_in`=1 moves to `S_AC`. Both give `z_out`=0.
- R4: In `S_DH`, `x_in`=0 moves to `S_G` with `z_out`=1, and `x_in`=1 moves to `S_AC` with `z_out`=0.
- R5: In `S_F`, `x_in`=0 keeps `S_F` and `x_in`=1 moves to `S_BE`. Both give `z_out`=1.
- R6: In `S_G`, `x_in`=0 keeps `S_G` with `z_out`=0, and `x_in`=1 moves to `S_DH` with `z_out`=1.
- R7: `z_out` follows a change of `x_in` within the same cycle, with no clock edge in between.
- R8: For every input sequence, `z_out` matches the unreduced eight-state table cycle by cycle. The state register only ever holds codes 0 to 4, and any other code steps to `S_AC`.
- R9: After `rst_n` rises, the machine stays in `S_AC` through the next two rising edges. Its first transition happens on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Reset, active low. Asserts asynchronously and releases through a synchroniser |
| x_in | input | 1 | Serial input bit, sampled at each rising edge |
| z_out | output | 1 | Mealy output, a function of the present state and `x_in` |

## Verification
Every pair of the five merged states can be told apart by an input sequence of at most two bits. A wrong internal state therefore shows up as a wrong `z_out` within two cycles of being entered, unless the input happens to steer both paths alike. The bench applies every 7-bit sequence from reset and a long pseudo-random stream. It compares each cycle against a model of the original eight-row table, so a bad merge or a wrong next-state entry is exposed within a couple of cycles. Directed steps check each transition, the same-cycle output response, and the timing of reset assertion and release.

// File: rtl/mealy_fsm_pkg.sv
package mealy_fsm_pkg;
  localparam int unsigned NUM_STATES = 5;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);
  localparam int unsigned SYNC_DEPTH = 2;

  typedef logic [STATE_W-1:0] st_code_t;

  localparam st_code_t S_AC = st_code_t'(0);
  localparam st_code_t S_BE = st_code_t'(1);
  localparam st_code_t S_DH = st_code_t'(2);
  localparam st_code_t S_F  = st_code_t'(3);
  localparam st_code_t S_G  = st_code_t'(4);
endpackage

// File: rtl/mealy_rst_sync.sv
module mealy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/mealy_next_state.sv
module mealy_next_state
  import mealy_fsm_pkg::*;
(
  input  st_code_t cur_st,
  input  logic     x_bit,
  output st_code_t nxt_st
);
  always_comb begin
    unique case (cur_st)
      S_AC:    nxt_st = x_bit ? S_BE : S_F;
      S_BE:    nxt_st = x_bit ? S_AC : S_DH;
      S_DH:    nxt_st = x_bit ? S_AC : S_G;
      S_F:     nxt_st = x_bit ? S_BE : S_F;
      S_G:     nxt_st = x_bit ? S_DH : S_G;
      default: nxt_st = S_AC;
    endcase
  end
endmodule

// File: rtl/mealy_out_logic.sv
module mealy_out_logic
  import mealy_fsm_pkg::*;
(
  input  st_code_t cur_st,
  input  logic     x_bit,
  output logic     z_bit
);
  always_comb begin
    unique case (cur_st)
      S_DH:    z_bit = !x_bit;
      S_F:     z_bit = 1'b1;
      S_G:     z_bit = x_bit;
      default: z_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mealy_reduced_fsm.sv
module mealy_reduced_fsm
  import mealy_fsm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic z_out
);
  logic     rst_int_n;
  st_code_t state_q;
  st_code_t state_d;

  mealy_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_int_n (rst_int_n)
  );

  mealy_next_state u_next (
    .cur_st (state_q),
    .x_bit  (x_in),
    .nxt_st (state_d)
  );

  mealy_out_logic u_out (
    .cur_st (state_q),
    .x_bit  (x_in),
    .z_bit  (z_out)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_AC;
    else            state_q <= state_d;
  end

  // R8: only the five legal codes are ever held
  p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    state_q < st_code_t'(NUM_STATES));

  // R9: the internal reset pins the machine to S_AC
  p_hold_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> state_q == S_AC);

  // R5: S_F with a zero input stays put, and drives a one
  p_f_self_loop_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_F && !x_in) |=> state_q == S_F);

  p_f_output_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    state_q == S_F |-> z_out);

  // R6: S_G with a zero input stays put
  p_g_self_loop_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_G && !x_in) |=> state_q == S_G);

  // R4: S_DH with a one input returns to S_AC
  p_dh_return_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_DH && x_in) |=> state_q == S_AC);

  // R2: S_AC never raises the output
  p_ac_quiet_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    state_q == S_AC |-> !z_out);
endmodule

// File: tb/sim_mealy_reduced_fsm.sv
module sim_mealy_reduced_fsm;
  logic clk;
  logic rst_n;
  logic x_in;
  logic z_out;

  int n_tests;
  int n_fail;
  int m_st;   // model state: 0..7 = rows A..H

  mealy_reduced_fsm u0 (.clk(clk), .rst_n(rst_n), .x_in(x_in), .z_out(z_out));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic int tbl_next(int s, logic x);
    case (s)
      0: return x ? 1 : 5;
      1: return x ? 2 : 3;
      2: return x ? 4 : 5;
      3: return x ? 0 : 6;
      4: return x ? 2 : 3;
      5: return x ? 1 : 5;
      6: return x ? 7 : 6;
      default: return x ? 0 : 6;
    endcase
  endfunction

  function automatic logic tbl_z(int s, logic x);
    case (s)
      3, 7: return !x;
      5:    return 1'b1;
      6:    return x;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x_in  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_st  = 0;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic step(string req, logic v);
    @(negedge clk);
    x_in = v;
    #3;
    chk(req, z_out, tbl_z(m_st, v));
    @(posedge clk);
    m_st = tbl_next(m_st, v);
  endtask

  task automatic step_exp(string req, logic v, logic exp);
    @(negedge clk);
    x_in = v;
    #3;
    chk(req, z_out, exp);
    @(posedge clk);
    m_st = tbl_next(m_st, v);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    x_in    = 1'b0;
    m_st    = 0;
    repeat (3) @(posedge clk);

    // R1: reset state, output low for both input values
    #3; x_in = 1'b1; #1; chk("R1", z_out, 1'b0);
    x_in = 1'b0; #1; chk("R1", z_out, 1'b0);

    // R9: release, two held edges, transition on the third
    @(negedge clk);
    rst_n = 1'b1;
    x_in  = 1'b0;
    @(posedge clk); #3; chk("R9", z_out, 1'b0);
    @(posedge clk); #3; chk("R9", z_out, 1'b0);
    @(posedge clk); #3; chk("R9", z_out, 1'b1);

    // directed walk through every transition of the five classes
    do_reset();
    step_exp("R2", 1'b1, 1'b0);   // AC -> BE
    step_exp("R3", 1'b0, 1'b0);   // BE -> DH
    step_exp("R4", 1'b0, 1'b1);   // DH -> G
    step_exp("R6", 1'b0, 1'b0);   // G  -> G
    step_exp("R6", 1'b1, 1'b1);   // G  -> DH
    step_exp("R4", 1'b1, 1'b0);   // DH -> AC
    step_exp("R2", 1'b0, 1'b0);   // AC -> F
    step_exp("R5", 1'b0, 1'b1);   // F  -> F
    step_exp("R5", 1'b1, 1'b1);   // F  -> BE
    step_exp("R3", 1'b1, 1'b0);   // BE -> AC
    step_exp("R2", 1'b0, 1'b0);   // AC -> F, then check F still
    step_exp("R5", 1'b0, 1'b1);

    // R7: in S_G the output tracks x within one cycle
    do_reset();
    step("R7", 1'b1); step("R7", 1'b0); step("R7", 1'b0);   // now in G
    @(negedge clk);
    x_in = 1'b0; #2; chk("R7", z_out, 1'b0);
    x_in = 1'b1; #2; chk("R7", z_out, 1'b1);
    x_in = 1'b0; #2; chk("R7", z_out, 1'b0);

    // R1: asynchronous reset from S_F with x=1 drops z at once
    do_reset();
    step("R1", 1'b0);   // AC -> F
    @(negedge clk);
    x_in = 1'b1; #2; chk("R1", z_out, 1'b1);
    rst_n = 1'b0; #2; chk("R1", z_out, 1'b0);

    // R8: every 7-bit sequence from reset against the eight-row table
    for (int seq = 0; seq < 128; seq++) begin
      do_reset();
      for (int b = 0; b < 7; b++) step("R8", seq[b]);
    end

    // R8: long pseudo-random stream
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R8", lfsr[0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule